// File: doc/BRIEF.md
# DRAM-Resident Page Translation Table

This block keeps track of which physical pages currently sit in a DRAM cache region placed in front of non-volatile memory. Each occupied slot holds a page tag, a machine base for that page, a two-bit residency state that combines clean/dirty with direct/static, and two per-epoch access counters, one for reads and one for writes. Slots are handed out from an internal last-in-first-out free stack. The table has room for the nominal length plus one sixteenth of it.

Software or a migration engine drives one command port with a valid/ready handshake. The commands are lookup, allocate, release, state change, read count, write count and epoch clear. Every accepted command gets a registered response one cycle later. The response gives the hit status, the slot index, the state, the counters and the translated machine address (the stored page base joined with the request's in-page offset). Occupancy counts and the running dirty count are brought out as outputs.

Top module: `pgmap_top`

## Requirements
- R1: After reset or a clear command (opcode 6), `free_cnt` equals CAP = NOM_LEN + (NOM_LEN >> 4), `used_cnt` and `dirty_cnt` are 0, and every page misses. `cmd_ready` is 1 once reset is released.
- R2: Allocation (opcode 1) takes the slot on top of the free stack. After reset or clear the stack holds indices 0..CAP-1 with CAP-1 on top, so the first allocation gets CAP-1, the next CAP-2, and so on. A released slot is the next one handed out.
- R3: An accepted command gives `rsp_valid` exactly one cycle later. A lookup (opcode 0) ignores address bits [PAGE_W-1:0] when it matches. On a hit it returns `rsp_hit`=1, the slot index, the state, both counters, and `rsp_maddr` = stored page base with the request's low PAGE_W bits.
- R4: On a miss, `rsp_hit`=0, `rsp_idx` is all ones (the invalid marker), and the state, both counters and `rsp_maddr` are 0.
- R5: Allocation of a page that is already present, or allocation when `free_cnt` is 0, sets `rsp_err` and changes neither the table nor any count.
- R6: Release (2), state change (3), read count (4) or write count (5) on an absent page, and the reserved opcode 7, set `rsp_err` and leave the table and all counts unchanged.
- R7: `dirty_cnt` goes up by one on each allocation into a dirty state, and on every state change into a dirty state even if the entry was already dirty. It goes down by one when an entry in a dirty state is released.
- R8: Read and write counts (opcodes 4 and 5) each add one to the entry's own counter. The counters saturate at 2^CNT_W-1 and are zeroed when the slot is allocated.
- R9: `free_cnt` + `used_cnt` equals CAP after every command, and `used_cnt` equals the number of valid slots.
- R10: State encoding: 0 clean-direct, 1 clean-static, 2 dirty-direct, 3 dirty-static. Bit 1 set means dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Opcode: 0 lookup, 1 allocate, 2 release, 3 state change, 4 read count, 5 write count, 6 clear, 7 reserved |
| cmd_addr | input | ADDR_W | Physical address |
| cmd_state | input | 2 | State for allocate or state change |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Command rejected |
| rsp_hit | output | 1 | Page was present before the command |
| rsp_idx | output | IDX_W | Slot index, all ones when none |
| rsp_state | output | 2 | Entry state |
| rsp_rd | output | CNT_W | Epoch read counter |
| rsp_wr | output | CNT_W | Epoch write counter |
| rsp_maddr | output | ADDR_W | Translated machine address |
| free_cnt | output | IDX_W | Free stack depth |
| used_cnt | output | IDX_W | Valid entry count |
| dirty_cnt | output | DIRTY_W | Running dirty count |

## Verification
The bench builds the table with a 16-bit address, 8 offset bits, NOM_LEN of 16 (so CAP is 17, which exercises the one-sixteenth oversize) and 3-bit counters. With 3-bit counters, saturation at 7 is reached after a handful of read commands. With 17 slots, filling the table until allocation is refused is a short loop. It then checks slot reuse after a release and the index order after a clear.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  typedef enum logic [2:0] {
    OP_LOOK  = 3'd0,
    OP_SETUP = 3'd1,
    OP_FREE  = 3'd2,
    OP_SHIFT = 3'd3,
    OP_RD    = 3'd4,
    OP_WR    = 3'd5,
    OP_CLEAR = 3'd6,
    OP_RSVD  = 3'd7
  } pm_op_e;

  // R10: numeric order is the precedence order, bit 1 marks dirty
  typedef enum logic [1:0] {
    PS_CLEAN_DIR  = 2'd0,
    PS_CLEAN_STAT = 2'd1,
    PS_DIRTY_DIR  = 2'd2,
    PS_DIRTY_STAT = 2'd3
  } pm_state_e;

  function automatic logic st_dirty(input logic [1:0] s);
    return s[1];
  endfunction
endpackage

// File: rtl/pgmap_freestack.sv
module pgmap_freestack #(
  parameter int CAP   = 17,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             pop,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  output logic [IDX_W-1:0] top_idx,
  output logic [IDX_W-1:0] depth
);
  logic [IDX_W-1:0] stk [CAP];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < CAP; i++) stk[i] <= IDX_W'(i);
      depth <= IDX_W'(CAP);
    end else if (push) begin
      stk[depth] <= push_idx;
      depth      <= depth + IDX_W'(1);
    end else if (pop) begin
      depth <= depth - IDX_W'(1);
    end
  end

  always_comb begin
    top_idx = '0;
    if (depth != '0) top_idx = stk[depth - IDX_W'(1)];
  end

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> depth != '0);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> depth < IDX_W'(CAP));
endmodule

// File: rtl/pgmap_cam.sv
module pgmap_cam #(
  parameter int CAP   = 17,
  parameter int IDX_W = 5,
  parameter int TAG_W = 20,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [1:0]       hit_state,
  output logic [CNT_W-1:0] hit_rd,
  output logic [CNT_W-1:0] hit_wr,
  output logic [TAG_W-1:0] hit_base,
  output logic [CAP-1:0]   valid_o,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_state,
  input  logic             alloc,
  input  logic             dealloc,
  input  logic             set_st,
  input  logic             inc_rd,
  input  logic             inc_wr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CAP-1:0]   match;
  logic [TAG_W-1:0] base_a [CAP];
  logic [1:0]       st_a   [CAP];
  logic [CNT_W-1:0] rd_a   [CAP];
  logic [CNT_W-1:0] wr_a   [CAP];

  for (genvar g = 0; g < CAP; g++) begin : g_slot
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic [TAG_W-1:0] b_q;
    logic [1:0]       s_q;
    logic [CNT_W-1:0] r_q;
    logic [CNT_W-1:0] w_q;
    logic             sel;

    assign sel = (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        v_q <= 1'b0;
        t_q <= '0;
        b_q <= '0;
        s_q <= '0;
        r_q <= '0;
        w_q <= '0;
      end else if (sel) begin
        if (alloc) begin
          v_q <= 1'b1;
          t_q <= look_tag;
          b_q <= look_tag;
          s_q <= wr_state;
          r_q <= '0;
          w_q <= '0;
        end
        if (dealloc) v_q <= 1'b0;
        if (set_st) s_q <= wr_state;
        if (inc_rd && r_q != CNT_MAX) r_q <= r_q + CNT_W'(1);
        if (inc_wr && w_q != CNT_MAX) w_q <= w_q + CNT_W'(1);
      end
    end

    assign match[g]   = v_q && (t_q == look_tag);
    assign valid_o[g] = v_q;
    assign base_a[g]  = b_q;
    assign st_a[g]    = s_q;
    assign rd_a[g]    = r_q;
    assign wr_a[g]    = w_q;
  end

  always_comb begin
    hit       = |match;
    hit_idx   = '0;
    hit_state = '0;
    hit_rd    = '0;
    hit_wr    = '0;
    hit_base  = '0;
    for (int i = 0; i < CAP; i++) begin
      if (match[i]) begin
        hit_idx   = hit_idx | IDX_W'(i);
        hit_state = hit_state | st_a[i];
        hit_rd    = hit_rd | rd_a[i];
        hit_wr    = hit_wr | wr_a[i];
        hit_base  = hit_base | base_a[i];
      end
    end
  end

  // R5
  uniq_tag_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  // R8
  alloc_free_slot_chk: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !valid_o[wr_idx]);
endmodule

// File: rtl/pgmap_top.sv
module pgmap_top #(
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 12,
  parameter int NOM_LEN = 16,
  parameter int CNT_W   = 8,
  parameter int DIRTY_W = 16,
  localparam int CAP    = NOM_LEN + (NOM_LEN >> 4),
  localparam int IDX_W  = $clog2(CAP + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [1:0]         cmd_state,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic               rsp_hit,
  output logic [IDX_W-1:0]   rsp_idx,
  output logic [1:0]         rsp_state,
  output logic [CNT_W-1:0]   rsp_rd,
  output logic [CNT_W-1:0]   rsp_wr,
  output logic [ADDR_W-1:0]  rsp_maddr,
  output logic [IDX_W-1:0]   free_cnt,
  output logic [IDX_W-1:0]   used_cnt,
  output logic [DIRTY_W-1:0] dirty_cnt
);
  import pgmap_pkg::*;

  localparam int TAG_W = ADDR_W - PAGE_W;
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  pm_op_e           op;
  logic             acc;
  logic [TAG_W-1:0] tag;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [1:0]       hit_state;
  logic [CNT_W-1:0] hit_rd;
  logic [CNT_W-1:0] hit_wr;
  logic [TAG_W-1:0] hit_base;
  logic [CAP-1:0]   valid_v;
  logic [IDX_W-1:0] top_idx;
  logic             err;
  logic             ok;
  logic             do_setup, do_free, do_shift, do_rd, do_wr, do_clr;
  logic [IDX_W-1:0] wr_idx;

  assign op  = pm_op_e'(cmd_op);
  assign acc = cmd_valid && cmd_ready;
  assign tag = cmd_addr[ADDR_W-1:PAGE_W];

  always_comb begin
    unique case (op)
      OP_SETUP:                       err = hit || (free_cnt == '0);
      OP_FREE, OP_SHIFT, OP_RD, OP_WR: err = !hit;
      OP_RSVD:                        err = 1'b1;
      default:                        err = 1'b0;
    endcase
  end

  assign ok       = acc && !err;
  assign do_setup = ok && op == OP_SETUP;
  assign do_free  = ok && op == OP_FREE;
  assign do_shift = ok && op == OP_SHIFT;
  assign do_rd    = ok && op == OP_RD;
  assign do_wr    = ok && op == OP_WR;
  assign do_clr   = ok && op == OP_CLEAR;
  assign wr_idx   = do_setup ? top_idx : hit_idx;

  pgmap_cam #(
    .CAP(CAP), .IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_cam (
    .clk(clk), .rst(rst), .clr(do_clr),
    .look_tag(tag),
    .hit(hit), .hit_idx(hit_idx), .hit_state(hit_state),
    .hit_rd(hit_rd), .hit_wr(hit_wr), .hit_base(hit_base),
    .valid_o(valid_v),
    .wr_idx(wr_idx), .wr_state(cmd_state),
    .alloc(do_setup), .dealloc(do_free), .set_st(do_shift),
    .inc_rd(do_rd), .inc_wr(do_wr)
  );

  pgmap_freestack #(
    .CAP(CAP), .IDX_W(IDX_W)
  ) u_stack (
    .clk(clk), .rst(rst), .clr(do_clr),
    .pop(do_setup), .push(do_free), .push_idx(hit_idx),
    .top_idx(top_idx), .depth(free_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_ready <= 1'b0;
      used_cnt  <= '0;
      dirty_cnt <= '0;
    end else begin
      cmd_ready <= 1'b1;
      if (do_clr) begin
        used_cnt  <= '0;
        dirty_cnt <= '0;
      end else begin
        if (do_setup) used_cnt <= used_cnt + IDX_W'(1);
        if (do_free)  used_cnt <= used_cnt - IDX_W'(1);
        if ((do_setup || do_shift) && st_dirty(cmd_state))
          dirty_cnt <= dirty_cnt + DIRTY_W'(1);
        else if (do_free && st_dirty(hit_state))
          dirty_cnt <= dirty_cnt - DIRTY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= IDX_NONE;
      rsp_state <= '0;
      rsp_rd    <= '0;
      rsp_wr    <= '0;
      rsp_maddr <= '0;
    end else begin
      rsp_valid <= acc;
      if (acc) begin
        rsp_err   <= err;
        rsp_hit   <= hit;
        rsp_idx   <= do_setup ? top_idx : (hit ? hit_idx : IDX_NONE);
        rsp_state <= do_setup ? cmd_state : (hit ? hit_state : 2'd0);
        rsp_rd    <= hit ? hit_rd : '0;
        rsp_wr    <= hit ? hit_wr : '0;
        rsp_maddr <= hit ? {hit_base, cmd_addr[PAGE_W-1:0]} : '0;
      end
    end
  end

  // R9
  inv_sum_chk: assert property (@(posedge clk) disable iff (rst)
    32'(free_cnt) + 32'(used_cnt) == CAP);
  // R9
  used_match_chk: assert property (@(posedge clk) disable iff (rst)
    32'(used_cnt) == $countones(valid_v));
  // R3
  rsp_lat_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);
  // R3
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !rsp_valid);
  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit && !(rsp_idx != IDX_NONE)) |-> (rsp_rd == '0 && rsp_wr == '0 && rsp_maddr == '0));
  // R5
  setup_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_SETUP && err) |=> (free_cnt == $past(free_cnt) && used_cnt == $past(used_cnt)));
  // R6
  absent_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && err) |=> (dirty_cnt == $past(dirty_cnt) && valid_v == $past(valid_v)));
endmodule

// File: tb/sim_pgmap_top.sv
module sim_pgmap_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CAP = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_addr = '0;
  logic [1:0]  cmd_state = '0;
  logic        rsp_valid, rsp_err, rsp_hit;
  logic [4:0]  rsp_idx;
  logic [1:0]  rsp_state;
  logic [2:0]  rsp_rd, rsp_wr;
  logic [15:0] rsp_maddr;
  logic [4:0]  free_cnt, used_cnt;
  logic [7:0]  dirty_cnt;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgmap_top #(.ADDR_W(AW), .PAGE_W(8), .NOM_LEN(16), .CNT_W(3), .DIRTY_W(8)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_state(cmd_state),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_hit(rsp_hit),
    .rsp_idx(rsp_idx), .rsp_state(rsp_state), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
    .rsp_maddr(rsp_maddr), .free_cnt(free_cnt), .used_cnt(used_cnt),
    .dirty_cnt(dirty_cnt)
  );

  // op[40:38] addr[37:22] st[21:20] err[19] hit[18] idx[17:13] dirty[12:5] free[4:0]
  localparam logic [40:0] VEC [10] = '{
    {3'd1, 16'h1200, 2'd1, 1'b0, 1'b0, 5'd16, 8'd0, 5'd16}, // R2 first slot CAP-1
    {3'd1, 16'h3400, 2'd2, 1'b0, 1'b0, 5'd15, 8'd1, 5'd15}, // R2 R7 dirty setup
    {3'd0, 16'h1234, 2'd0, 1'b0, 1'b1, 5'd16, 8'd1, 5'd15}, // R3 offset ignored
    {3'd1, 16'h12FF, 2'd0, 1'b1, 1'b1, 5'd16, 8'd1, 5'd15}, // R5 duplicate
    {3'd2, 16'h5500, 2'd0, 1'b1, 1'b0, 5'd31, 8'd1, 5'd15}, // R6 free absent
    {3'd3, 16'h1200, 2'd3, 1'b0, 1'b1, 5'd16, 8'd2, 5'd15}, // R7 shift to dirty
    {3'd3, 16'h3400, 2'd2, 1'b0, 1'b1, 5'd15, 8'd3, 5'd15}, // R7 already dirty
    {3'd2, 16'h3456, 2'd0, 1'b0, 1'b1, 5'd15, 8'd2, 5'd16}, // R7 free dirty
    {3'd1, 16'h7700, 2'd0, 1'b0, 1'b0, 5'd15, 8'd2, 5'd15}, // R2 LIFO reuse
    {3'd0, 16'h9900, 2'd0, 1'b0, 1'b0, 5'd31, 8'd2, 5'd15}  // R4 miss
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [15:0] a, input logic [1:0] st);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_state = st; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", cmd_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 free", free_cnt, CAP);
    chk("R1 used", used_cnt, 0);
    chk("R1 dirty", dirty_cnt, 0);

    for (int i = 0; i < 10; i++) begin
      cmd(VEC[i][40:38], VEC[i][37:22], VEC[i][21:20]);
      chk("R3 rsp_valid", rsp_valid, 1);
      chk("R5 R6 err", rsp_err, VEC[i][19]);
      chk("R3 hit", rsp_hit, VEC[i][18]);
      chk("R2 idx", rsp_idx, VEC[i][17:13]);
      chk("R7 dirty", dirty_cnt, VEC[i][12:5]);
      chk("R9 free", free_cnt, VEC[i][4:0]);
      chk("R9 sum", free_cnt + used_cnt, CAP);
    end
    // R10 state 3 stored for 0x1200
    cmd(3'd0, 16'h1200, 2'd0);
    chk("R10 state", rsp_state, 3);
    // R3 translation
    cmd(3'd0, 16'h1234, 2'd0);
    chk("R3 maddr", rsp_maddr, 16'h1234);

    // R8 counting
    for (int i = 0; i < 3; i++) cmd(3'd4, 16'h7700, 2'd0);
    cmd(3'd5, 16'h7745, 2'd0);
    cmd(3'd0, 16'h77AB, 2'd0);
    chk("R8 rd", rsp_rd, 3);
    chk("R8 wr", rsp_wr, 1);
    chk("R3 idx", rsp_idx, 15);
    chk("R3 maddr off", rsp_maddr, 16'h77AB);
    for (int i = 0; i < 9; i++) cmd(3'd4, 16'h7700, 2'd0);
    cmd(3'd0, 16'h7700, 2'd0);
    chk("R8 saturate", rsp_rd, 7);

    // R6 absent commands leave state alone
    cmd(3'd5, 16'hAB00, 2'd0);
    chk("R6 wr absent err", rsp_err, 1);
    cmd(3'd3, 16'hAB00, 2'd3);
    chk("R6 shift absent err", rsp_err, 1);
    chk("R6 dirty unchanged", dirty_cnt, 2);
    cmd(3'd7, 16'h7700, 2'd0);
    chk("R6 reserved err", rsp_err, 1);
    cmd(3'd0, 16'h7700, 2'd0);
    chk("R6 wr unchanged", rsp_wr, 1);

    // R5 fill to capacity
    for (int i = 0; i < 15; i++) begin
      cmd(3'd1, 16'(16'h8000 + i * 16'h0100), 2'd0);
      chk("R2 fill idx", rsp_idx, 14 - i);
    end
    chk("R5 full free", free_cnt, 0);
    chk("R9 full used", used_cnt, CAP);
    cmd(3'd1, 16'hF000, 2'd2);
    chk("R5 full err", rsp_err, 1);
    chk("R5 full free kept", free_cnt, 0);
    chk("R5 full dirty kept", dirty_cnt, 2);
    cmd(3'd0, 16'hF000, 2'd0);
    chk("R5 not added", rsp_hit, 0);

    // R7 free dirty entry, R2 reuse
    cmd(3'd2, 16'h1200, 2'd0);
    chk("R7 free dirty", dirty_cnt, 1);
    cmd(3'd1, 16'hF000, 2'd2);
    chk("R2 reuse idx", rsp_idx, 16);
    chk("R7 setup dirty", dirty_cnt, 2);

    // R1 clear
    cmd(3'd6, 16'h0000, 2'd0);
    chk("R1 clear free", free_cnt, CAP);
    chk("R1 clear used", used_cnt, 0);
    chk("R1 clear dirty", dirty_cnt, 0);
    cmd(3'd0, 16'h77AB, 2'd0);
    chk("R4 miss hit", rsp_hit, 0);
    chk("R4 miss idx", rsp_idx, 31);
    chk("R4 miss rd", rsp_rd, 0);
    chk("R4 miss wr", rsp_wr, 0);
    chk("R4 miss maddr", rsp_maddr, 0);
    cmd(3'd1, 16'h4400, 2'd0);
    chk("R2 refill idx", rsp_idx, 16);
    cmd(3'd1, 16'h4500, 2'd1);
    chk("R2 refill next", rsp_idx, 15);
    cmd(3'd0, 16'h4500, 2'd0);
    chk("R8 zero on setup rd", rsp_rd, 0);
    chk("R8 zero on setup wr", rsp_wr, 0);
    chk("R10 clean static", rsp_state, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule